// File: doc/BRIEF.md
# Reduced-Width Five-Level Symbol FIR Section

This block is one section of a tapped-delay-line FIR filter. Its input stream carries only five symbol values, so each tap needs no multiplier. A tap shifts its coefficient by zero or one place and negates it when the symbol is negative. A zero symbol gates the coefficient to zero before that logic.

Sign-extension bits toggle whenever a small product changes sign. To stop this, every partial product is cut to a run-time width `m` and kept as an unsigned field whose upper bits stay at zero. The width `m` is set from the largest coefficient magnitude held in the section. Each negative product in that form is too large by exactly 2^m. A separate correction path counts the negative taps and subtracts that count shifted by `m`. This makes the output equal to the full-precision sum.

Coefficients are written one at a time into a staging bank. The whole bank moves into the working bank when the next sample is accepted, and the width is recomputed at that same edge.

Top module: `rsym_fir_section`

## Requirements
- R1: Symbols are 3-bit two's complement codes, with 000=0, 001=+1, 010=+2, 111=-1 and 110=-2; the other three codes are not legal. The edge that accepts a sample (`sym_vld` high) registers `y_out` = sum over taps i of c[i]*x[n-i] and raises `y_vld`. Here x[n] is the sample being accepted and tap i uses the i-th older accepted sample.
- R2: After reset, `y_vld` is 0, `y_out` is 0 and `pp_width` is 2. All working and staged coefficients are zero, and the delay line holds zero symbols.
- R3: `pp_width` equals the bit length of the peak coefficient magnitude plus 2, where the bit length of 0 is 0. Its range is 2 to 12 for 10-bit coefficients, and a coefficient of -512 counts as magnitude 512.
- R4: A coefficient write (`coef_we`, `coef_idx`, `coef_data`) changes neither the output nor `pp_width` by itself. The next accepted sample still uses the old coefficients. At that same edge the staged bank becomes the working bank and `pp_width` updates; later samples use the new bank.
- R5: Results are exact at the extremes, including every tap at -512 or +511 with every symbol at -2.
- R6: On cycles without an accepted sample, `y_vld` is 0 and `y_out` holds its last value.
- R7: A tap whose symbol is zero contributes nothing, whatever its coefficient.
- R8: The delay line advances only on accepted samples, so idle cycles between samples do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| coef_we | input | 1 | Stage one coefficient write |
| coef_idx | input | 3 | Tap index of the write |
| coef_data | input | 10 | Two's complement coefficient |
| sym_vld | input | 1 | Accept `sym_in` on this edge |
| sym_in | input | 3 | Five-level symbol |
| y_vld | output | 1 | `y_out` was updated on the last edge |
| y_out | output | 15 | Two's complement filter output |
| pp_width | output | 4 | Partial-product width in use |

## Verification
The output and `pp_width` are set by the same edge that accepts a sample, so each result is due one edge after `sym_vld` is driven. The bench drives on the falling edge and checks on the next falling edge. It also checks the staging rule: a result that follows a coefficient load is computed by the bench with the old coefficients, and the width change is expected at that same edge. Idle cycles are checked on every falling edge for a low valid and a held output.

// File: rtl/rsym_pkg.sv
package rsym_pkg;
  localparam int SYM_W = 3;

  typedef struct packed {
    logic zero;
    logic neg;
    logic dbl;
  } sym_dec_t;

  function automatic sym_dec_t sym_decode(input logic [SYM_W-1:0] s);
    sym_dec_t d;
    d.zero = (s == 3'b000);
    d.neg  = s[2];
    d.dbl  = (s == 3'b010) || (s == 3'b110);
    return d;
  endfunction
endpackage

// File: rtl/rsym_peak_width.sv
module rsym_peak_width #(
  parameter int TAPS   = 8,
  parameter int COEF_W = 10,
  parameter int MW_W   = 4
) (
  input  logic [TAPS*COEF_W-1:0] coef_flat,
  output logic [MW_W-1:0]        width
);
  logic [COEF_W:0] mag [TAPS];
  logic [COEF_W:0] mag_or;
  logic [MW_W-1:0] blen;

  for (genvar g = 0; g < TAPS; g++) begin : g_abs
    logic [COEF_W:0] ext;
    assign ext    = {coef_flat[g*COEF_W+COEF_W-1], coef_flat[g*COEF_W +: COEF_W]};
    assign mag[g] = ext[COEF_W] ? (~ext + 1'b1) : ext;
  end

  // The OR of all magnitudes has the same leading one as their maximum.
  always_comb begin
    mag_or = '0;
    for (int i = 0; i < TAPS; i++) mag_or = mag_or | mag[i];
    blen = '0;
    for (int b = 0; b <= COEF_W; b++) if (mag_or[b]) blen = MW_W'(b + 1);
    width = blen + MW_W'(2);
  end
endmodule

// File: rtl/rsym_pp_tap.sv
module rsym_pp_tap
  import rsym_pkg::*;
#(
  parameter int COEF_W = 10,
  parameter int PP_W   = 12,
  parameter int MW_W   = 4
) (
  input  logic [COEF_W-1:0] coef,
  input  logic [SYM_W-1:0]  sym,
  input  logic [MW_W-1:0]   width,
  output logic [PP_W-1:0]   pat,
  output logic              neg
);
  sym_dec_t        dec;
  logic [COEF_W-1:0] cg;
  logic [PP_W-1:0] ext, mag, full, mask;

  always_comb begin
    dec  = sym_decode(sym);
    cg   = dec.zero ? '0 : coef;          // zero symbol gates the coefficient
    ext  = {{(PP_W-COEF_W){cg[COEF_W-1]}}, cg};
    mag  = dec.dbl ? (ext << 1) : ext;
    full = dec.neg ? (~mag + 1'b1) : mag;
    mask = ~({PP_W{1'b1}} << width);
    pat  = full & mask;                   // bits at and above width stay zero
    neg  = full[PP_W-1];
  end
endmodule

// File: rtl/rsym_comp_acc.sv
module rsym_comp_acc #(
  parameter int TAPS  = 8,
  parameter int PP_W  = 12,
  parameter int MW_W  = 4,
  parameter int OUT_W = 15
) (
  input  logic [TAPS*PP_W-1:0] pat_flat,
  input  logic [TAPS-1:0]      neg_vec,
  input  logic [MW_W-1:0]      width,
  output logic [OUT_W-1:0]     y_sum
);
  localparam int CNT_W = $clog2(TAPS + 1);

  logic [OUT_W-1:0] acc, corr;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    acc = '0;
    cnt = '0;
    for (int i = 0; i < TAPS; i++) begin
      acc = acc + OUT_W'(pat_flat[i*PP_W +: PP_W]);
      cnt = cnt + CNT_W'(neg_vec[i]);
    end
    corr  = OUT_W'(cnt) << width;   // compensation: one 2^m per negative tap
    y_sum = acc - corr;             // exact modulo 2^OUT_W; true sum fits
  end
endmodule

// File: rtl/rsym_fir_section.sv
module rsym_fir_section
  import rsym_pkg::*;
#(
  parameter int TAPS   = 8,
  parameter int COEF_W = 10
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        coef_we,
  input  logic [$clog2(TAPS)-1:0]     coef_idx,
  input  logic [COEF_W-1:0]           coef_data,
  input  logic                        sym_vld,
  input  logic [2:0]                  sym_in,
  output logic                        y_vld,
  output logic [COEF_W+1+$clog2(TAPS):0] y_out,
  output logic [$clog2(COEF_W+3)-1:0] pp_width
);
  localparam int PP_W   = COEF_W + 2;
  localparam int OUT_W  = COEF_W + 2 + $clog2(TAPS);
  localparam int MW_W   = $clog2(PP_W + 1);
  localparam int BANK_W = TAPS * COEF_W;
  localparam int HIST_W = (TAPS - 1) * SYM_W;

  logic [1:0]          rs_q;
  logic                rst_sync_n;
  logic [BANK_W-1:0]   shadow_q, shadow_d, act_q;
  logic                pend_q, pend_d, commit;
  logic [HIST_W-1:0]   hist_q, hist_d;
  logic [MW_W-1:0]     width_q, width_stage;
  logic [OUT_W-1:0]    y_q, y_sum;
  logic                vld_q;
  logic [TAPS*SYM_W-1:0] win;
  logic [TAPS*PP_W-1:0]  pat_flat;
  logic [TAPS-1:0]       neg_vec;

  // reset release synchronizer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  rsym_peak_width #(.TAPS(TAPS), .COEF_W(COEF_W), .MW_W(MW_W)) u_peak (
    .coef_flat(shadow_q), .width(width_stage));

  assign win = {hist_q, sym_in};

  for (genvar g = 0; g < TAPS; g++) begin : g_tap
    rsym_pp_tap #(.COEF_W(COEF_W), .PP_W(PP_W), .MW_W(MW_W)) u_tap (
      .coef (act_q[g*COEF_W +: COEF_W]),
      .sym  (win[g*SYM_W +: SYM_W]),
      .width(width_q),
      .pat  (pat_flat[g*PP_W +: PP_W]),
      .neg  (neg_vec[g]));
  end

  rsym_comp_acc #(.TAPS(TAPS), .PP_W(PP_W), .MW_W(MW_W), .OUT_W(OUT_W)) u_acc (
    .pat_flat(pat_flat), .neg_vec(neg_vec), .width(width_q), .y_sum(y_sum));

  // next state
  always_comb begin
    shadow_d = shadow_q;
    shadow_d[coef_idx*COEF_W +: COEF_W] = coef_data;
    commit = sym_vld & pend_q;
    pend_d = coef_we | (pend_q & ~sym_vld);
    hist_d = {hist_q[HIST_W-SYM_W-1:0], sym_in};
  end

  // registers with explicit enables
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      shadow_q <= '0;
      act_q    <= '0;
      pend_q   <= 1'b0;
      hist_q   <= '0;
      width_q  <= MW_W'(2);
      y_q      <= '0;
      vld_q    <= 1'b0;
    end else begin
      if (coef_we) shadow_q <= shadow_d;
      if (commit) begin
        act_q   <= shadow_q;
        width_q <= width_stage;
      end
      pend_q <= pend_d;
      if (sym_vld) begin
        hist_q <= hist_d;
        y_q    <= y_sum;
      end
      vld_q <= sym_vld;
    end
  end

  assign y_vld    = vld_q;
  assign y_out    = y_q;
  assign pp_width = width_q;
endmodule

// File: rtl/rsym_fir_chk.sv
module rsym_fir_chk #(
  parameter int TAPS   = 8,
  parameter int COEF_W = 10
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           sym_vld,
  input logic                           y_vld,
  input logic [COEF_W+1+$clog2(TAPS):0] y_out,
  input logic [$clog2(COEF_W+3)-1:0]    pp_width
);
  localparam int PP_W = COEF_W + 2;
  localparam int MW_W = $clog2(PP_W + 1);

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    sym_vld |=> y_vld);

  a_r6_no_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_vld |=> !y_vld);

  a_r6_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_vld |=> $stable(y_out));

  a_r4_width_at_sample: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_vld |=> $stable(pp_width));

  a_r3_width_range: assert property (@(posedge clk) disable iff (!rst_n)
    (pp_width >= MW_W'(2)) && (pp_width <= MW_W'(PP_W)));
endmodule

bind rsym_fir_section rsym_fir_chk #(.TAPS(TAPS), .COEF_W(COEF_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .sym_vld(sym_vld), .y_vld(y_vld),
  .y_out(y_out), .pp_width(pp_width));

// File: tb/sim_rsym_fir_section.sv
module sim_rsym_fir_section;
  logic        clk, rst_n, coef_we, sym_vld, y_vld;
  logic [2:0]  coef_idx, sym_in;
  logic [9:0]  coef_data;
  logic [14:0] y_out;
  logic [3:0]  pp_width;

  rsym_fir_section u0 (.clk(clk), .rst_n(rst_n), .coef_we(coef_we),
    .coef_idx(coef_idx), .coef_data(coef_data), .sym_vld(sym_vld),
    .sym_in(sym_in), .y_vld(y_vld), .y_out(y_out), .pp_width(pp_width));

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  localparam int NV = 24;
  localparam int SYMS [NV] = '{1,-2,0,2,-1,1,1,-2,2,0,-1,-2,
                               2,2,-1,0,1,-2,-2,1,0,2,-1,1};
  localparam int COEF_A [8] = '{3,-5,7,0,-1,2,-4,6};
  localparam int COEF_B [8] = '{511,-512,300,-1,0,128,-256,77};

  int checks = 0, errors = 0;
  int sh [8], ac [8], hist [8];
  int expw, expy;
  bit pend;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int width_of();
    int pk = 0, bl = 0;
    for (int i = 0; i < 8; i++) begin
      int a = (sh[i] < 0) ? -sh[i] : sh[i];
      if (a > pk) pk = a;
    end
    while ((pk >> bl) != 0) bl++;
    return bl + 2;
  endfunction

  task automatic wr(input int i, input int v);
    coef_we = 1'b1; coef_idx = 3'(i); coef_data = 10'(v);
    @(negedge clk);
    coef_we = 1'b0;
    sh[i] = v; pend = 1'b1;
    chk(y_vld == 1'b0 && int'(pp_width) == expw, "R4 write alone", int'(pp_width), expw);
  endtask

  task automatic push(input int s, input string req);
    int e = 0;
    sym_vld = 1'b1; sym_in = 3'(s);
    for (int i = 7; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = s;
    for (int i = 0; i < 8; i++) e += ac[i] * hist[i];
    if (pend) begin
      for (int i = 0; i < 8; i++) ac[i] = sh[i];
      expw = width_of(); pend = 1'b0;
    end
    expy = e;
    @(negedge clk);
    sym_vld = 1'b0;
    chk(y_vld == 1'b1 && int'($signed(y_out)) == expy, req, int'($signed(y_out)), expy);
    chk(int'(pp_width) == expw, "R3 width", int'(pp_width), expw);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(y_vld == 1'b0 && int'($signed(y_out)) == expy, "R6 hold", int'($signed(y_out)), expy);
    end
  endtask

  task automatic load(input int v [8]);
    for (int i = 0; i < 8; i++) wr(i, v[i]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int allv [8];
    rst_n = 1'b0; coef_we = 1'b0; coef_idx = '0; coef_data = '0;
    sym_vld = 1'b0; sym_in = '0;
    for (int i = 0; i < 8; i++) begin sh[i] = 0; ac[i] = 0; hist[i] = 0; end
    expw = 2; expy = 0; pend = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R2 reset state
    chk(y_vld == 1'b0, "R2 valid", int'(y_vld), 0);
    chk(y_out == '0, "R2 output", int'($signed(y_out)), 0);
    chk(pp_width == 4'd2, "R2 width", int'(pp_width), 2);

    // R4 staging: first sample after load uses old (zero) bank
    load(COEF_A);
    idle(2);
    for (int v = 0; v < NV/2; v++) push(SYMS[v], "R1 vector A");
    load(COEF_B);
    for (int v = NV/2; v < NV; v++) push(SYMS[v], "R1 vector B");

    // R8 gaps between samples
    push(1, "R8 gap"); idle(3); push(-2, "R8 gap"); idle(1); push(2, "R8 gap");

    // R7 zero symbols with large coefficients
    for (int k = 0; k < 9; k++) push(0, "R7 zero symbol");

    // R5 extremes
    for (int i = 0; i < 8; i++) allv[i] = -512;
    load(allv);
    for (int k = 0; k < 9; k++) push(-2, "R5 extreme neg");
    chk(int'($signed(y_out)) == 8192, "R5 peak value", int'($signed(y_out)), 8192);
    for (int i = 0; i < 8; i++) allv[i] = 511;
    load(allv);
    for (int k = 0; k < 9; k++) push(-2, "R5 extreme pos");
    chk(int'($signed(y_out)) == -8176, "R5 low value", int'($signed(y_out)), -8176);

    // R3 small widths
    for (int i = 0; i < 8; i++) allv[i] = 0;
    load(allv);
    push(1, "R3 zero bank");
    chk(pp_width == 4'd2, "R3 zero bank width", int'(pp_width), 2);
    wr(5, -1);
    push(-1, "R3 unit coef");
    push(1, "R3 unit coef");
    chk(pp_width == 4'd3, "R3 unit width", int'(pp_width), 3);
    wr(2, 64);
    push(2, "R3 mid coef"); push(-1, "R3 mid coef"); push(2, "R3 mid coef");
    idle(2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule